// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block sequences the movement of a set of wide floating-point registers between a register file and memory. A start pulse hands it a register list, a transfer direction, a bit-order selector and an addressing-mode flag. The sequencer then visits each selected register in turn. For every register it issues one block request made of `BEATS` word-sized beats, and it waits for an acknowledge or a fault on each beat. The register file and the data path sit outside the block. They use the register index and beat index that the block drives to route the data. The effective-address decoding that produces the starting address and the predecrement flag also sits outside.

The register list can come from a static field captured with the start pulse. It can also come at run time from the low bits of one of several data registers. An index chooses which data register. The addressing mode sets the order in which register numbers are scanned. A separate mode bit sets how mask bits map to register numbers. When the sequence ends, the block returns the final address so that the address register can be written back. No field of the floating-point status is touched: the block has no path to it.

Top module: `fpx_multi_xfer`

## Requirements
- R1: While reset is held, and after it is released, the block is idle: `busy`, `mem_req`, `done` and `fault` are all low.
- R2: `mem_we` is high on every request of a transfer when `to_mem` was 1 at start (register to memory). It is low when `to_mem` was 0 (memory to register). It does not change within a transfer.
- R3: When `dyn_sel` is 1 at start, the list is bits [8k+7:8k] of `dreg_low`, where k is `dyn_idx`. When `dyn_sel` is 0, the list is `static_list`.
- R4: When `rev_order` is 0, register n is selected by list bit n. When it is 1, register n is selected by list bit 7−n.
- R5: When `predec` is 1, the selected registers are visited from highest number to lowest. When it is 0, they are visited from lowest to highest. Registers that are not selected get no request.
- R6: With a running address A, a register's beats go to B, B+4 and B+8 in beat order 0, 1, 2, where B is A−12 when `predec` is 1 and A otherwise. After the register's last beat is acknowledged, A becomes A−12 (predecrement) or A+12. A starts at `base_addr`.
- R7: While a request waits for `mem_ack`, the request, the address, the register index and the beat index are held unchanged.
- R8: A `mem_fault` during a request ends the transfer and takes priority over a same-cycle `mem_ack`. In the next cycle `done` and `fault` are both high, with no further request. `final_addr` excludes the faulted register.
- R9: The cycle after the last beat of the last register is acknowledged, `done` is high for exactly one cycle with `fault` low, and `final_addr` holds the running address.
- R10: An empty list raises `done` in the cycle after start, with no request issued.
- R11: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| to_mem | input | 1 | 1: register to memory, 0: memory to register |
| rev_order | input | 1 | Mask bit mapping: 0 bit n = reg n, 1 bit 7−n = reg n |
| dyn_sel | input | 1 | Take the list from a data register |
| dyn_idx | input | 3 | Data register slot for the dynamic list |
| dreg_low | input | 64 | Low bytes of the data registers, slot k at [8k+7:8k] |
| static_list | input | 8 | Static register list |
| predec | input | 1 | Predecrement addressing mode |
| base_addr | input | 32 | Starting address |
| mem_ack | input | 1 | Beat completed |
| mem_fault | input | 1 | Beat access fault |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Beat request valid |
| mem_we | output | 1 | Request is a memory write |
| reg_idx | output | 3 | Register being moved |
| beat_idx | output | 2 | Word beat within the register |
| mem_addr | output | 32 | Byte address of the beat |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion was due to a fault (valid with done) |
| final_addr | output | 32 | Address for write-back |

## Verification
A corrupted pending-register set shows up at the ports on the very next request: either `reg_idx` names a register that is not in the list or is out of order, or `done` arrives early or late. A wrong running address or beat counter shows up on `mem_addr` in the first request cycle after the error. A stale direction latch flips `mem_we` within a transfer. Because the bench model predicts every port on every clock, each of these errors is caught in the cycle where it first becomes visible.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MOVE = 2'd1,
      ST_END  = 2'd2
   } fpx_state_e;
endpackage

// File: rtl/fpx_list_src.sv
module fpx_list_src #(
   parameter int NREG   = 8,
   parameter int NDREG  = 8,
   localparam int DIDX_W = $clog2(NDREG)
) (
   input  logic                    dyn_sel,
   input  logic [DIDX_W-1:0]       dyn_idx,
   input  logic [NDREG*NREG-1:0]   dreg_low,
   input  logic [NREG-1:0]         static_list,
   input  logic                    rev_order,
   output logic [NREG-1:0]         reg_mask
);
   logic [NREG-1:0] raw_list;

   assign raw_list = dyn_sel ? dreg_low[dyn_idx*NREG +: NREG] : static_list;

   for (genvar n = 0; n < NREG; n++) begin : g_map
      assign reg_mask[n] = rev_order ? raw_list[NREG-1-n] : raw_list[n];
   end
endmodule

// File: rtl/fpx_pick.sv
module fpx_pick #(
   parameter int NREG  = 8,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic [NREG-1:0]  pend,
   input  logic             from_top,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] lo_idx;
   logic [IDX_W-1:0] hi_idx;

   always_comb begin
      lo_idx = '0;
      hi_idx = '0;
      for (int n = NREG - 1; n >= 0; n--) begin
         if (pend[n]) lo_idx = IDX_W'(n);
      end
      for (int n = 0; n < NREG; n++) begin
         if (pend[n]) hi_idx = IDX_W'(n);
      end
   end

   assign idx = from_top ? hi_idx : lo_idx;
endmodule

// File: rtl/fpx_addr.sv
module fpx_addr #(
   parameter int ADDR_W      = 32,
   parameter int BEAT_W      = 2,
   parameter int WORD_BYTES  = 4,
   parameter int BLOCK_BYTES = 12
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic              predec,
   input  logic [BEAT_W-1:0] beat,
   output logic [ADDR_W-1:0] beat_addr,
   output logic [ADDR_W-1:0] next_addr
);
   localparam logic [ADDR_W-1:0] BLK  = ADDR_W'(BLOCK_BYTES);
   localparam logic [ADDR_W-1:0] WSTP = ADDR_W'(WORD_BYTES);

   logic [ADDR_W-1:0] blk_base;

   assign blk_base  = predec ? (cur_addr - BLK) : cur_addr;
   assign beat_addr = blk_base + (ADDR_W'(beat) * WSTP);
   assign next_addr = predec ? (cur_addr - BLK) : (cur_addr + BLK);
endmodule

// File: rtl/fpx_multi_xfer.sv
module fpx_multi_xfer
   import fpx_pkg::*;
#(
   parameter int NREG   = 8,
   parameter int NDREG  = 8,
   parameter int WORD_W = 32,
   parameter int BEATS  = 3,
   parameter int ADDR_W = 32,
   localparam int IDX_W  = $clog2(NREG),
   localparam int DIDX_W = $clog2(NDREG),
   localparam int BEAT_W = $clog2(BEATS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  to_mem,
   input  logic                  rev_order,
   input  logic                  dyn_sel,
   input  logic [DIDX_W-1:0]     dyn_idx,
   input  logic [NDREG*NREG-1:0] dreg_low,
   input  logic [NREG-1:0]       static_list,
   input  logic                  predec,
   input  logic [ADDR_W-1:0]     base_addr,
   input  logic                  mem_ack,
   input  logic                  mem_fault,
   output logic                  busy,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [IDX_W-1:0]      reg_idx,
   output logic [BEAT_W-1:0]     beat_idx,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic                  done,
   output logic                  fault,
   output logic [ADDR_W-1:0]     final_addr
);
   localparam int WORD_BYTES  = WORD_W / 8;
   localparam int BLOCK_BYTES = WORD_BYTES * BEATS;
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
   localparam logic [ADDR_W-1:0] STEP_A    = ADDR_W'(WORD_BYTES);

   if (NREG < 2 || (1 << IDX_W) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two and at least 2");
   end
   if ((1 << DIDX_W) != NDREG) begin : g_bad_ndreg
      $error("NDREG must be a power of two");
   end
   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (BEATS < 2) begin : g_bad_beats
      $error("BEATS must be at least 2");
   end

   fpx_state_e        state;
   logic [NREG-1:0]   pend;
   logic [NREG-1:0]   pend_clr;
   logic [NREG-1:0]   map_mask;
   logic [IDX_W-1:0]  pick_idx;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] next_addr;
   logic [ADDR_W-1:0] beat_addr;
   logic [BEAT_W-1:0] beat;
   logic              we_q;
   logic              pd_q;
   logic              fault_q;

   fpx_list_src #(.NREG(NREG), .NDREG(NDREG)) u_list (
      .dyn_sel     (dyn_sel),
      .dyn_idx     (dyn_idx),
      .dreg_low    (dreg_low),
      .static_list (static_list),
      .rev_order   (rev_order),
      .reg_mask    (map_mask)
   );

   fpx_pick #(.NREG(NREG)) u_pick (
      .pend     (pend),
      .from_top (pd_q),
      .idx      (pick_idx)
   );

   fpx_addr #(
      .ADDR_W      (ADDR_W),
      .BEAT_W      (BEAT_W),
      .WORD_BYTES  (WORD_BYTES),
      .BLOCK_BYTES (BLOCK_BYTES)
   ) u_addr (
      .cur_addr  (cur_addr),
      .predec    (pd_q),
      .beat      (beat),
      .beat_addr (beat_addr),
      .next_addr (next_addr)
   );

   assign pend_clr = pend & ~(NREG'(1) << pick_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pend     <= '0;
         cur_addr <= '0;
         beat     <= '0;
         we_q     <= 1'b0;
         pd_q     <= 1'b0;
         fault_q  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  pend     <= map_mask;
                  we_q     <= to_mem;
                  pd_q     <= predec;
                  cur_addr <= base_addr;
                  beat     <= '0;
                  fault_q  <= 1'b0;
                  state    <= (|map_mask) ? ST_MOVE : ST_END;
               end
            end
            ST_MOVE: begin
               if (mem_fault) begin
                  fault_q <= 1'b1;
                  state   <= ST_END;
               end else if (mem_ack) begin
                  if (beat == LAST_BEAT) begin
                     beat     <= '0;
                     cur_addr <= next_addr;
                     pend     <= pend_clr;
                     if (pend_clr == '0) state <= ST_END;
                  end else begin
                     beat <= beat + BEAT_W'(1);
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state != ST_IDLE);
   assign mem_req    = (state == ST_MOVE);
   assign mem_we     = we_q;
   assign reg_idx    = pick_idx;
   assign beat_idx   = beat;
   assign mem_addr   = beat_addr;
   assign done       = (state == ST_END);
   assign fault      = (state == ST_END) && fault_q;
   assign final_addr = cur_addr;

   AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && $past(mem_req) |-> $stable(mem_we)); // R2
   AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && !mem_fault && beat_idx != LAST_BEAT |=>
         mem_req && mem_addr == $past(mem_addr) + STEP_A && reg_idx == $past(reg_idx)); // R6
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack && !mem_fault |=>
         mem_req && $stable(mem_addr) && $stable(reg_idx) && $stable(beat_idx)); // R7
   AST_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_fault |=> done && fault && !mem_req); // R8
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy); // R9
   AST_EMPTY_LIST: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && map_mask == '0 |=> done && !fault && !mem_req); // R10
endmodule

// File: tb/fpx_multi_xfer_tb_top.sv
`timescale 1ns/1ps
module fpx_multi_xfer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        to_mem = 1'b0;
   logic        rev_order = 1'b0;
   logic        dyn_sel = 1'b0;
   logic [2:0]  dyn_idx = '0;
   logic [63:0] dreg_low = 64'h5A3C_0F81_FF00_A512;
   logic [7:0]  static_list = '0;
   logic        predec = 1'b0;
   logic [31:0] base_addr = '0;
   logic        mem_ack = 1'b0;
   logic        mem_fault = 1'b0;
   logic        busy, mem_req, mem_we, done, fault;
   logic [2:0]  reg_idx;
   logic [1:0]  beat_idx;
   logic [31:0] mem_addr, final_addr;

   int total = 0;
   int bad = 0;

   // behavioural reference state
   int          m_phase;   // 0 idle, 1 moving, 2 finishing
   int          m_q[$];
   int          m_beat;
   logic [31:0] m_addr;
   bit          m_we, m_pd, m_fault;
   int          ack_cnt;
   int          fault_at = -1;
   int          tick = 0;
   int          stall_mode = 0;
   int          req_seen;

   always #2.5 clk = ~clk;

   fpx_multi_xfer dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem),
      .rev_order(rev_order), .dyn_sel(dyn_sel), .dyn_idx(dyn_idx),
      .dreg_low(dreg_low), .static_list(static_list), .predec(predec),
      .base_addr(base_addr), .mem_ack(mem_ack), .mem_fault(mem_fault),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .reg_idx(reg_idx),
      .beat_idx(beat_idx), .mem_addr(mem_addr), .done(done), .fault(fault),
      .final_addr(final_addr)
   );

   task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // reference model, advanced on the same edge as the design
   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_q.delete(); m_beat = 0; m_addr = '0;
         m_we = 0; m_pd = 0; m_fault = 0;
      end else if (m_phase == 2) begin
         m_phase = 0;
      end else if (m_phase == 0) begin
         if (start) begin
            logic [7:0] lst;
            lst = dyn_sel ? dreg_low[dyn_idx*8 +: 8] : static_list;
            m_q.delete();
            for (int k = 0; k < 8; k++) begin
               int r;
               r = predec ? 7 - k : k;
               if (rev_order ? lst[7-r] : lst[r]) m_q.push_back(r);
            end
            m_we = to_mem; m_pd = predec; m_addr = base_addr;
            m_beat = 0; m_fault = 0; ack_cnt = 0;
            m_phase = (m_q.size() != 0) ? 1 : 2;
         end
      end else begin
         if (mem_fault) begin
            m_fault = 1; m_phase = 2;
         end else if (mem_ack) begin
            if (m_beat == 2) begin
               m_beat = 0;
               m_addr = m_pd ? m_addr - 12 : m_addr + 12;
               void'(m_q.pop_front());
               if (m_q.size() == 0) m_phase = 2;
            end else begin
               m_beat++;
            end
         end
      end
   end

   // compare every cycle, then drive the memory responder
   always @(negedge clk) begin
      if (rst_n) begin
         logic [31:0] exp_a;
         cmp("R11 busy", 32'(busy), 32'(m_phase != 0));
         cmp("R7 mem_req", 32'(mem_req), 32'(m_phase == 1));
         if (m_phase == 1) begin
            exp_a = (m_pd ? m_addr - 12 : m_addr) + 32'(4 * m_beat);
            cmp("R6 mem_addr", mem_addr, exp_a);
            cmp("R6 beat_idx", 32'(beat_idx), 32'(m_beat));
            cmp("R5 reg_idx", 32'(reg_idx), 32'(m_q[0]));
            cmp("R2 mem_we", 32'(mem_we), 32'(m_we));
            req_seen++;
         end
         cmp("R9 done", 32'(done), 32'(m_phase == 2));
         cmp("R8 fault", 32'(fault), 32'(m_phase == 2 && m_fault));
         if (m_phase == 2) cmp("R9 final_addr", final_addr, m_addr);
      end
      tick++;
      mem_ack = 1'b0;
      mem_fault = 1'b0;
      if (mem_req) begin
         if (fault_at >= 0 && ack_cnt == fault_at) begin
            mem_fault = 1'b1;
            mem_ack = 1'b1;  // same-cycle ack must lose to the fault
         end else begin
            mem_ack = (stall_mode == 0) ? 1'b1 : ((tick % 3) != 1);
            if (mem_ack) ack_cnt++;
         end
      end
   end

   task automatic xfer(bit we, bit rev, bit dyn, int didx, logic [7:0] lst,
                       bit pd, logic [31:0] base, int f_at, bit poke);
      int guard;
      @(negedge clk);
      to_mem = we; rev_order = rev; dyn_sel = dyn; dyn_idx = 3'(didx);
      static_list = lst; predec = pd; base_addr = base; fault_at = f_at;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R11: a second start with a different setup while busy
         @(negedge clk);
         static_list = ~lst; predec = ~pd; to_mem = ~we; base_addr = base ^ 32'hFF0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (m_phase != 0 && guard < 400) begin
         @(negedge clk);
         guard++;
      end
      cmp("R9 transfer ended", 32'(m_phase), 32'd0);
      fault_at = -1;
   endtask

   initial begin
      #1000000;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp("R1 busy in reset", 32'(busy), 32'd0);
      cmp("R1 req in reset", 32'(mem_req), 32'd0);
      cmp("R1 done in reset", 32'(done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R1 idle after reset", {29'd0, busy, mem_req, fault}, 32'd0);

      // R4 R5 R6: plain order, post-increment, to memory
      xfer(1, 0, 0, 0, 8'hA5, 0, 32'h0000_1000, -1, 0);
      // R5: predecrement, two registers at the ends
      xfer(0, 0, 0, 0, 8'h81, 1, 32'h0000_2000, -1, 0);
      // R4: reversed mapping, bits 0,1 select registers 7,6
      xfer(1, 1, 0, 0, 8'h03, 0, 32'h0000_3000, -1, 0);
      // R4 R5: reversed mapping with predecrement
      xfer(0, 1, 0, 0, 8'h0F, 1, 32'h0000_4000, -1, 0);
      // R3: dynamic list from slot 5 and slot 2
      xfer(1, 0, 1, 5, 8'h00, 0, 32'h0000_5000, -1, 0);
      xfer(0, 1, 1, 2, 8'hFF, 1, 32'h0000_6000, -1, 0);
      // R10: empty list, done in the cycle after start
      req_seen = 0;
      @(negedge clk);
      static_list = 8'h00; dyn_sel = 0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cmp("R10 done after empty start", 32'(done), 32'd1);
      cmp("R10 no request", 32'(mem_req), 32'd0);
      @(negedge clk);
      cmp("R10 no request issued", 32'(req_seen), 32'd0);
      // R8: fault on the fifth beat, with stalls
      stall_mode = 1;
      xfer(1, 0, 0, 0, 8'h7E, 0, 32'h0000_7000, 4, 0);
      xfer(0, 0, 0, 0, 8'hFF, 1, 32'h0000_8000, 0, 0);
      // full list predecrement with stalls
      xfer(1, 0, 0, 0, 8'hFF, 1, 32'h0001_0000, -1, 0);
      // R11: start while busy
      xfer(1, 0, 0, 0, 8'h11, 0, 32'h0000_9000, -1, 1);
      // mixed runs
      for (int i = 0; i < 30; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         stall_mode = int'(rv[20]);
         dreg_low = {rv, rv ^ 32'h9E37_79B9};
         xfer(rv[0], rv[1], rv[2], int'(rv[5:3]), rv[13:6], rv[14],
              {16'h0, rv[31:18], 2'b00}, (rv[17:15] == 3'd0) ? int'(rv[24:21]) : -1,
              rv[25] & rv[26]);
      end
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule